// File: doc/BRIEF.md
# Banked Program Fetch Address Generator

This block forms the 24-bit instruction fetch address of an 8/16-bit processor. The address is an 8-bit bank register joined above a 16-bit program counter. Each cycle an event vector arrives from decode, already resolved. It carries one bit for each kind of control-flow update: advance to the next byte, near jump, relative branch, long jump, long call, long return, interrupt return, hardware interrupt, software break and coprocessor trap. The block applies the update that wins by priority, and the new address shows at the outputs from the next cycle.

The bank register is narrow on purpose. Only long control flow writes it, and the three trap kinds force it to zero. Arithmetic on the program counter wraps inside the current 64K bank. The stack side of the block works in two directions. A push request returns the live bank value on a data output. For long returns and interrupt returns, the bank that comes back is taken from a dedicated stack input. No operation pulls the bank register from the stack in any other way.

Top module: `prog_addr_gen`

## Requirements
- R1: A synchronous active-high `rst` sets both the bank and the program counter to zero. Reset wins over every event.
- R2: `fetch_addr` carries the bank in bits 23:16 and the program counter in bits 15:0, both as registered values.
- R3: Event bit 0 (advance) adds one to the program counter. From 0xFFFF the counter goes to 0x0000, and the bank stays as it was.
- R4: Event bits 3 (long jump) and 4 (long call) load the bank from `tgt_bank` and the program counter from `tgt_pc`.
- R5: Event bits 5 (long return) and 6 (interrupt return) load the bank from `stk_bank` and the program counter from `tgt_pc`.
- R6: Event bits 7 (hardware interrupt), 8 (software break) and 9 (coprocessor trap) each set the bank to zero and load `vec_pc` into the program counter, in the same cycle.
- R7: Event bit 1 (near jump) loads `tgt_pc`. Event bit 2 (relative branch) adds `rel_off` to the program counter modulo 65536. In both cases the bank stays as it was.
- R8: When more than one event bit is set, the order is: any trap (bits 9..7), then a stack-sourced long load (bits 6,5), then a target-sourced long load (bits 4,3), then the near jump, then the branch, then the advance. With no bit set, the bank and the program counter hold.
- R9: While `push_req` is high, `push_valid` is high and `push_bank` equals the current bank in the same cycle. The request does not alter the bank. With no request, `push_bank` reads zero.
- R10: The bank and the program counter ignore `tgt_bank`, `stk_bank`, `tgt_pc`, `rel_off` and `vec_pc` when no event bit that uses them is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev | input | 10 | Decoded event bits, indexed as in R3 to R7 |
| tgt_pc | input | 16 | Jump, call or return target offset |
| tgt_bank | input | 8 | Bank for long jump and long call |
| stk_bank | input | 8 | Bank popped from the stack for long and interrupt returns |
| rel_off | input | 16 | Two's-complement branch displacement |
| vec_pc | input | 16 | Trap vector offset |
| push_req | input | 1 | Request for the bank value to be pushed |
| fetch_addr | output | 24 | Next opcode fetch address |
| bank_q | output | 8 | Current bank register |
| pc_q | output | 16 | Current program counter |
| push_valid | output | 1 | Push data is valid |
| push_bank | output | 8 | Bank value for the stack |

## Verification
A wrong bank appears in the top byte of `fetch_addr` in the cycle after the bad update. It persists until the next long event or trap, so a carry out of the counter, or a short jump that touches the bank, shows at once as a fetch in a different bank. A misordered priority shows as a wrong offset or bank after a single cycle. For that reason every one of the 1024 event combinations is applied from a known state and compared against an arithmetic model one cycle later. The push path is combinational and is compared in the same cycle as its request.

// File: rtl/pag_pkg.sv
package pag_pkg;

    localparam int EV_W = 10;

    localparam int EV_INC      = 0;
    localparam int EV_NEAR     = 1;
    localparam int EV_BRANCH   = 2;
    localparam int EV_LJMP     = 3;
    localparam int EV_LCALL    = 4;
    localparam int EV_LRET     = 5;
    localparam int EV_IRET     = 6;
    localparam int EV_HWINT    = 7;
    localparam int EV_BRK      = 8;
    localparam int EV_COP      = 9;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_INC,
        ACT_BRANCH,
        ACT_NEAR,
        ACT_LONG_TGT,
        ACT_LONG_STK,
        ACT_TRAP
    } act_e;

    function automatic logic is_trap(input logic [EV_W-1:0] e);
        return e[EV_HWINT] | e[EV_BRK] | e[EV_COP];
    endfunction

    function automatic logic is_long_stk(input logic [EV_W-1:0] e);
        return e[EV_LRET] | e[EV_IRET];
    endfunction

    function automatic logic is_long_tgt(input logic [EV_W-1:0] e);
        return e[EV_LJMP] | e[EV_LCALL];
    endfunction

endpackage

// File: rtl/pag_arbiter.sv
module pag_arbiter
    import pag_pkg::*;
(
    input  logic [EV_W-1:0] ev,
    output act_e            act
);
    always_comb begin
        if (is_trap(ev))               act = ACT_TRAP;
        else if (is_long_stk(ev))      act = ACT_LONG_STK;
        else if (is_long_tgt(ev))      act = ACT_LONG_TGT;
        else if (ev[EV_NEAR])          act = ACT_NEAR;
        else if (ev[EV_BRANCH])        act = ACT_BRANCH;
        else if (ev[EV_INC])           act = ACT_INC;
        else                           act = ACT_HOLD;
    end
endmodule

// File: rtl/pag_pc_next.sv
module pag_pc_next
    import pag_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  act_e            act,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] tgt_pc,
    input  logic [PC_W-1:0] rel_off,
    input  logic [PC_W-1:0] vec_pc,
    output logic [PC_W-1:0] pc_nxt
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    always_comb begin
        unique case (act)
            ACT_TRAP:     pc_nxt = vec_pc;
            ACT_LONG_STK,
            ACT_LONG_TGT,
            ACT_NEAR:     pc_nxt = tgt_pc;
            ACT_BRANCH:   pc_nxt = pc + rel_off;
            ACT_INC:      pc_nxt = pc + ONE;
            default:      pc_nxt = pc;
        endcase
    end
endmodule

// File: rtl/pag_bank_next.sv
module pag_bank_next
    import pag_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  act_e              act,
    input  logic [BANK_W-1:0] bank,
    input  logic [BANK_W-1:0] tgt_bank,
    input  logic [BANK_W-1:0] stk_bank,
    output logic [BANK_W-1:0] bank_nxt
);
    always_comb begin
        unique case (act)
            ACT_TRAP:     bank_nxt = '0;
            ACT_LONG_STK: bank_nxt = stk_bank;
            ACT_LONG_TGT: bank_nxt = tgt_bank;
            default:      bank_nxt = bank;
        endcase
    end
endmodule

// File: rtl/prog_addr_gen.sv
module prog_addr_gen
    import pag_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int PC_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [EV_W-1:0]        ev,
    input  logic [PC_W-1:0]        tgt_pc,
    input  logic [BANK_W-1:0]      tgt_bank,
    input  logic [BANK_W-1:0]      stk_bank,
    input  logic [PC_W-1:0]        rel_off,
    input  logic [PC_W-1:0]        vec_pc,
    input  logic                   push_req,
    output logic [BANK_W+PC_W-1:0] fetch_addr,
    output logic [BANK_W-1:0]      bank_q,
    output logic [PC_W-1:0]        pc_q,
    output logic                   push_valid,
    output logic [BANK_W-1:0]      push_bank
);
    act_e              act;
    logic [PC_W-1:0]   pc_nxt;
    logic [BANK_W-1:0] bank_nxt;

    pag_arbiter u_arb (
        .ev  (ev),
        .act (act)
    );

    pag_pc_next #(.PC_W(PC_W)) u_pc (
        .act     (act),
        .pc      (pc_q),
        .tgt_pc  (tgt_pc),
        .rel_off (rel_off),
        .vec_pc  (vec_pc),
        .pc_nxt  (pc_nxt)
    );

    pag_bank_next #(.BANK_W(BANK_W)) u_bank (
        .act      (act),
        .bank     (bank_q),
        .tgt_bank (tgt_bank),
        .stk_bank (stk_bank),
        .bank_nxt (bank_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            pc_q   <= '0;
        end else begin
            bank_q <= bank_nxt;
            pc_q   <= pc_nxt;
        end
    end

    assign fetch_addr = {bank_q, pc_q};
    assign push_valid = push_req;
    assign push_bank  = push_req ? bank_q : '0;
endmodule

// File: rtl/pag_checker.sv
module pag_checker
    import pag_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int PC_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [EV_W-1:0]   ev,
    input logic [PC_W-1:0]   tgt_pc,
    input logic [PC_W-1:0]   vec_pc,
    input logic              push_req,
    input logic [BANK_W-1:0] bank_q,
    input logic [PC_W-1:0]   pc_q,
    input logic              push_valid,
    input logic [BANK_W-1:0] push_bank
);
    localparam logic [EV_W-1:0] INC_ONLY = EV_W'(1);

    // R10: without a long event or trap the bank keeps its value
    p_bank_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (ev[9:3] == '0) |=> (bank_q == $past(bank_q)));

    // R6: every trap kind zeroes the bank and takes the vector
    p_trap_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (ev[9:7] != '0) |=> (bank_q == '0 && pc_q == $past(vec_pc)));

    // R3: advance past the top of the bank wraps without a carry
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (ev == INC_ONLY && pc_q == '1) |=> (pc_q == '0 && bank_q == $past(bank_q)));

    // R7: near jump loads the offset only
    p_near_r7: assert property (@(posedge clk) disable iff (rst)
        (ev[1] && ev[9:3] == '0) |=> (pc_q == $past(tgt_pc) && bank_q == $past(bank_q)));

    // R9: push data matches the live bank
    p_push_r9: assert property (@(posedge clk) disable iff (rst)
        push_req |-> (push_valid && push_bank == bank_q));
endmodule

bind prog_addr_gen pag_checker #(.BANK_W(BANK_W), .PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .tgt_pc     (tgt_pc),
    .vec_pc     (vec_pc),
    .push_req   (push_req),
    .bank_q     (bank_q),
    .pc_q       (pc_q),
    .push_valid (push_valid),
    .push_bank  (push_bank)
);

// File: tb/test_prog_addr_gen.sv
`timescale 1ns/1ps
module test_prog_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  ev = '0;
    logic [15:0] tgt_pc = '0, rel_off = '0, vec_pc = '0;
    logic [7:0]  tgt_bank = '0, stk_bank = '0;
    logic        push_req = 1'b0;
    logic [23:0] fetch_addr;
    logic [7:0]  bank_q, push_bank;
    logic [15:0] pc_q;
    logic        push_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prog_addr_gen i_prog_addr_gen (
        .clk(clk), .rst(rst), .ev(ev), .tgt_pc(tgt_pc), .tgt_bank(tgt_bank),
        .stk_bank(stk_bank), .rel_off(rel_off), .vec_pc(vec_pc),
        .push_req(push_req), .fetch_addr(fetch_addr), .bank_q(bank_q),
        .pc_q(pc_q), .push_valid(push_valid), .push_bank(push_bank)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one clock with the given event; values settle 1 ns after the edge
    task automatic step(input logic [9:0] e);
        ev = e;
        @(posedge clk);
        #1;
        ev = '0;
    endtask

    task automatic long_to(input logic [7:0] b, input logic [15:0] p);
        tgt_bank = b;
        tgt_pc   = p;
        step(10'b00_0000_1000);
    endtask

    function automatic logic [23:0] model(input logic [9:0] e, input logic [7:0] b,
                                          input logic [15:0] p);
        if (e[9:7] != 0)        return {8'h00, vec_pc};
        else if (e[6] | e[5])   return {stk_bank, tgt_pc};
        else if (e[4] | e[3])   return {tgt_bank, tgt_pc};
        else if (e[1])          return {b, tgt_pc};
        else if (e[2])          return {b, p + rel_off};
        else if (e[0])          return {b, p + 16'd1};
        else                    return {b, p};
    endfunction

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {8'h0, fetch_addr}, 32'h0);
        rst = 1'b0;

        // R4 and R2: sweep every bank through a long jump, then a call
        for (int b = 0; b < 256; b++) begin
            long_to(8'(b), 16'(b * 257 + 3));
            check("R4 ljmp", {8'h0, fetch_addr}, {8'h0, 8'(b), 16'(b * 257 + 3)});
            check("R2 split", {8'h0, bank_q, pc_q}, {8'h0, fetch_addr});
        end
        tgt_bank = 8'h3C; tgt_pc = 16'h0100;
        step(10'b00_0001_0000);
        check("R4 lcall", {8'h0, fetch_addr}, 32'h003C0100);

        // R3: wrap at the top of the bank
        long_to(8'hA7, 16'hFFFE);
        step(10'b1);
        check("R3 inc", {8'h0, fetch_addr}, 32'h00A7FFFF);
        step(10'b1);
        check("R3 wrap", {8'h0, fetch_addr}, 32'h00A70000);

        // R7: near jump and branch keep the bank, branch wraps modulo 64K
        long_to(8'h55, 16'h1000);
        tgt_pc = 16'hFFF0; step(10'b10);
        check("R7 near", {8'h0, fetch_addr}, 32'h0055FFF0);
        rel_off = 16'h0020; step(10'b100);
        check("R7 branch wrap", {8'h0, fetch_addr}, 32'h00550010);
        rel_off = 16'hFFE0; step(10'b100);
        check("R7 branch back", {8'h0, fetch_addr}, 32'h0055FFF0);

        // R5: both return kinds take the stack bank
        stk_bank = 8'h9D; tgt_pc = 16'h4321; step(10'b00_0010_0000);
        check("R5 lret", {8'h0, fetch_addr}, 32'h009D4321);
        stk_bank = 8'h12; tgt_pc = 16'h8765; step(10'b00_0100_0000);
        check("R5 iret", {8'h0, fetch_addr}, 32'h00128765);

        // R6: each trap kind zeroes the bank
        for (int t = 7; t < 10; t++) begin
            long_to(8'hEE, 16'h2222);
            vec_pc = 16'(16'hFFE0 + t);
            step(10'(1 << t));
            check("R6 trap", {8'h0, fetch_addr}, {16'h0, 16'(16'hFFE0 + t)});
        end

        // R9: push returns the bank without changing it
        long_to(8'hC4, 16'h0077);
        push_req = 1'b1; #1;
        check("R9 push data", {23'h0, push_valid, push_bank}, {23'h0, 1'b1, 8'hC4});
        step(10'b0);
        check("R9 push keeps", {8'h0, fetch_addr}, 32'h00C40077);
        push_req = 1'b0; #1;
        check("R9 idle zero", {24'h0, push_bank}, 32'h0);

        // R10: operand inputs ignored when no event uses them
        tgt_bank = 8'h11; stk_bank = 8'h22; tgt_pc = 16'hAAAA; vec_pc = 16'hBBBB;
        rel_off = 16'h0005;
        step(10'b0);
        check("R10 idle", {8'h0, fetch_addr}, 32'h00C40077);
        step(10'b101);
        check("R10 branch only", {8'h0, fetch_addr}, 32'h00C4007C);

        // R8: every event combination against the model
        for (int v = 0; v < 1024; v++) begin
            logic [23:0] exp;
            logic [7:0]  b0;
            logic [15:0] p0;
            b0 = 8'(v) ^ 8'h5A;
            p0 = 16'(v * 64 + 16'hF000);
            long_to(b0, p0);
            tgt_pc   = 16'(16'h1234 + v);
            tgt_bank = ~8'(v);
            stk_bank = 8'(v + 3);
            rel_off  = 16'(v * 37);
            vec_pc   = 16'(16'hFFF0 - v);
            exp = model(10'(v), b0, p0);
            step(10'(v));
            check("R8 priority", {8'h0, fetch_addr}, {8'h0, exp});
        end

        // R1: reset over a pending trap
        rst = 1'b1;
        step(10'b10_0000_0000);
        check("R1 reset wins", {8'h0, fetch_addr}, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule